// File: doc/BRIEF.md
# One-Wire Bus Master Slot Engine

This block runs bit-level transactions on one open-drain one-wire bus. A local controller gives it one command at a time: write a one, write a zero, read a bit, or issue a reset and look for a presence pulse. The engine pulls the line low for the programmed time and then lets it go. A read slot watches how long the line stays low. A reset samples the line at the presence point. At the end of each slot a one-cycle done strobe carries a 2-bit result.

All durations come in on ports as whole microseconds. They are counted with a 1 µs tick made from the system clock. The prescaler restarts when a command is accepted, so every slot edge falls a whole number of ticks after the start. The master never drives the line high. Its only output is a pull-low enable, and an external pull-up brings the released line back high.

The line input passes through a two-flop synchronizer before any decision. The timing ports must stay stable while a slot runs. At regular speed the reset low time plus the bus rise time has to stay under 960 µs, so that other devices on the bus are not disturbed. Meeting that limit is left to whoever programs the reset low time.

Top module: `ow_slot_master`

## Requirements
- R1: After reset the pull-low enable, busy and done outputs are all 0 and result is 0. The pull-low enable is only ever 1 while a command is busy.
- R2: Write-one (cmd 1) holds the line low for exactly `t_w1_low_i` µs from the clock edge that accepts start. Done is raised exactly `t_slot_i + t_recov_i` µs after that edge, with result 0.
- R3: Write-zero (cmd 0) holds the line low for exactly `t_w0_low_i` µs. Done is raised exactly `t_slot_i + t_recov_i` µs after the start edge, with result 0.
- R4: Read (cmd 2) holds the line low for `t_rd_low_i` µs and then releases it. If the synchronized line is seen high while fewer than `t_rd_valid_i` µs have elapsed since the start edge, the result is 1.
- R5: In a read slot, the result is 0 if the line is first seen high at or after `t_rd_valid_i` µs. It is also 0 if the line is still low when `t_rd_valid_i + 2` µs is reached, which ends the watch. Done comes exactly `t_slot_i + t_recov_i` µs after the start edge whatever the bit.
- R6: Reset (cmd 3) with the synchronized line already low never drives the bus. It raises done at the accepting edge with result 2 (fault).
- R7: A reset otherwise holds the line low for `t_rst_low_i` µs and releases it. It samples the line once at `t_rst_low_i + t_pres_wait_i + t_pres_len_i/2` µs: low gives result 1 (present), high gives result 0 (absent).
- R8: A reset samples the line again at `t_rst_low_i + t_rst_high_i` µs and raises done there. If the line is low at that point, the result is 2 (fault) in place of the presence result.
- R9: A start pulse that arrives while busy has no effect. The slot in progress keeps its timing and result, and no extra done appears.
- R10: Done is a one-cycle pulse, one per accepted command. Busy is 1 from the edge that accepts start until the edge that raises done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Command strobe, taken only when idle |
| cmd_i | input | 2 | 0 write-zero, 1 write-one, 2 read, 3 reset/presence |
| t_w1_low_i | input | TW | Low time of a write-one, µs |
| t_w0_low_i | input | TW | Low time of a write-zero, µs |
| t_rd_low_i | input | TW | Low time that opens a read, µs |
| t_rd_valid_i | input | TW | Read decision threshold from slot start, µs |
| t_slot_i | input | TW | Slot length, µs |
| t_recov_i | input | TW | Recovery time after a slot, µs |
| t_rst_low_i | input | TW | Reset low time, µs |
| t_pres_wait_i | input | TW | Wait from release to presence start, µs |
| t_pres_len_i | input | TW | Presence pulse length, µs |
| t_rst_high_i | input | TW | Reset high window after release, µs |
| line_i | input | 1 | Bus level as read at the pin |
| line_oe_o | output | 1 | 1 pulls the bus low, 0 releases it |
| busy_o | output | 1 | A command is in progress |
| done_o | output | 1 | One-cycle end-of-command strobe |
| result_o | output | 2 | Read bit, or 0 absent, 1 present, 2 fault for reset |

## Verification
The two writes are run with different low times. This confirms that the low pulse width follows the selected command and the programmed value, while the slot end stays fixed. Reads are run against a target that releases early, one that releases just past the threshold, and one that never releases, which separates a decision made at the threshold from one made by the bounded-wait timeout. Resets are run with a responding device, an empty bus, a line stuck low before the reset, and a presence pulse that runs past the high window, covering each of the three result codes and both fault points. A start pulse sent in the middle of a slot checks that a busy engine ignores it.

// File: rtl/ow_pkg.sv
package ow_pkg;

    typedef enum logic [1:0] {
        CMD_WR0 = 2'd0,
        CMD_WR1 = 2'd1,
        CMD_RD  = 2'd2,
        CMD_RST = 2'd3
    } ow_cmd_e;

    localparam logic [1:0] RES_LO    = 2'd0;
    localparam logic [1:0] RES_HI    = 2'd1;
    localparam logic [1:0] RES_FAULT = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_REL,
        ST_WATCH,
        ST_TAIL,
        ST_PRES,
        ST_RECOV
    } ow_state_e;

endpackage

// File: rtl/ow_tick_gen.sv
module ow_tick_gen #(
    parameter int CLK_HZ  = 50_000_000,
    parameter int TICK_HZ = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic tick_o
);
    localparam int DIV = (CLK_HZ / TICK_HZ) > 0 ? (CLK_HZ / TICK_HZ) : 1;
    localparam int CW  = DIV > 1 ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick_o = (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q + 1'b1;
        if (clr_i || tick_o) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    generate
        if (DIV > 1) begin : g_spacing
            // R2: ticks never come on two cycles in a row when dividing
            a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate

endmodule

// File: rtl/ow_line_sync.sv
module ow_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], line_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '1;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign line_o = sh_q[STAGES-1];

endmodule

// File: rtl/ow_slot_fsm.sv
module ow_slot_fsm
    import ow_pkg::*;
#(
    parameter int TW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          line_s_i,
    input  logic          start_i,
    input  logic [1:0]    cmd_i,
    input  logic [TW-1:0] t_w1_low_i,
    input  logic [TW-1:0] t_w0_low_i,
    input  logic [TW-1:0] t_rd_low_i,
    input  logic [TW-1:0] t_rd_valid_i,
    input  logic [TW-1:0] t_slot_i,
    input  logic [TW-1:0] t_recov_i,
    input  logic [TW-1:0] t_rst_low_i,
    input  logic [TW-1:0] t_pres_wait_i,
    input  logic [TW-1:0] t_pres_len_i,
    input  logic [TW-1:0] t_rst_high_i,
    output logic          tick_clr_o,
    output logic          line_oe_o,
    output logic          busy_o,
    output logic          done_o,
    output logic [1:0]    result_o
);
    localparam int EW = TW + 2;

    typedef struct packed {
        ow_state_e     state;
        ow_cmd_e       cmd;
        logic [EW-1:0] elapsed;
        logic          oe;
        logic          done;
        logic          bitv;
        logic [1:0]    result;
    } fsm_t;

    fsm_t d, q;

    logic [EW-1:0] el_nx;
    logic [EW-1:0] low_tgt;
    logic [EW-1:0] slot_end;
    logic [EW-1:0] watch_end;
    logic [EW-1:0] pres_pt;
    logic [EW-1:0] rst_end;
    logic          accept;

    function automatic logic [EW-1:0] ext(input logic [TW-1:0] v);
        return {{(EW-TW){1'b0}}, v};
    endfunction

    always_comb begin
        el_nx     = q.elapsed + {{(EW-1){1'b0}}, tick_i};
        slot_end  = ext(t_slot_i) + ext(t_recov_i);
        watch_end = ext(t_rd_valid_i) + EW'(2);
        pres_pt   = ext(t_rst_low_i) + ext(t_pres_wait_i) + ext(t_pres_len_i >> 1);
        rst_end   = ext(t_rst_low_i) + ext(t_rst_high_i);
        unique case (q.cmd)
            CMD_WR1: low_tgt = ext(t_w1_low_i);
            CMD_WR0: low_tgt = ext(t_w0_low_i);
            CMD_RD:  low_tgt = ext(t_rd_low_i);
            default: low_tgt = ext(t_rst_low_i);
        endcase
    end

    assign accept     = (q.state == ST_IDLE) && start_i;
    assign tick_clr_o = accept;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (start_i) begin
                    d.cmd     = ow_cmd_e'(cmd_i);
                    d.elapsed = '0;
                    d.result  = RES_LO;
                    d.bitv    = 1'b0;
                    if ((ow_cmd_e'(cmd_i) == CMD_RST) && !line_s_i) begin
                        d.done   = 1'b1;
                        d.result = RES_FAULT;
                    end else begin
                        d.state = ST_LOW;
                        d.oe    = 1'b1;
                    end
                end
            end
            ST_LOW: begin
                d.elapsed = el_nx;
                if (el_nx >= low_tgt) begin
                    d.oe = 1'b0;
                    unique case (q.cmd)
                        CMD_RD:  d.state = ST_WATCH;
                        CMD_RST: d.state = ST_PRES;
                        default: d.state = ST_REL;
                    endcase
                end
            end
            ST_REL: begin
                d.elapsed = el_nx;
                if (el_nx >= slot_end) begin
                    d.done   = 1'b1;
                    d.result = RES_LO;
                    d.state  = ST_IDLE;
                end
            end
            ST_WATCH: begin
                d.elapsed = el_nx;
                if (line_s_i) begin
                    d.bitv  = (q.elapsed < ext(t_rd_valid_i));
                    d.state = ST_TAIL;
                end else if (el_nx >= watch_end) begin
                    d.bitv  = 1'b0;
                    d.state = ST_TAIL;
                end
            end
            ST_TAIL: begin
                d.elapsed = el_nx;
                if (el_nx >= slot_end) begin
                    d.done   = 1'b1;
                    d.result = {1'b0, q.bitv};
                    d.state  = ST_IDLE;
                end
            end
            ST_PRES: begin
                d.elapsed = el_nx;
                if (el_nx >= pres_pt) begin
                    d.result = line_s_i ? RES_LO : RES_HI;
                    d.state  = ST_RECOV;
                end
            end
            ST_RECOV: begin
                d.elapsed = el_nx;
                if (el_nx >= rst_end) begin
                    d.done  = 1'b1;
                    d.state = ST_IDLE;
                    if (!line_s_i) begin
                        d.result = RES_FAULT;
                    end
                end
            end
            default: begin
                d.state = ST_IDLE;
                d.oe    = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, cmd: CMD_WR0, elapsed: '0, oe: 1'b0,
                   done: 1'b0, bitv: 1'b0, result: RES_LO};
        end else begin
            q <= d;
        end
    end

    assign line_oe_o = q.oe;
    assign busy_o    = (q.state != ST_IDLE);
    assign done_o    = q.done;
    assign result_o  = q.result;

    // R1: the bus is pulled low only while a command runs
    a_r1_drive_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        line_oe_o |-> busy_o);

    // R10: done lasts a single cycle
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6: a reset onto a low line reports a fault without driving
    a_r6_prefault_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && (cmd_i == 2'd3) && !line_s_i)
        |=> (done_o && (result_o == RES_FAULT) && !line_oe_o && !busy_o));

    // R9: a start while busy leaves the latched command alone
    a_r9_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(q.cmd));

    // R5: the read watch never outlasts its bound
    a_r5_watch_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.state == ST_WATCH) && (ext(t_rd_low_i) <= watch_end))
        |-> (q.elapsed <= watch_end));

endmodule

// File: rtl/ow_slot_master.sv
module ow_slot_master #(
    parameter int CLK_HZ = 50_000_000,
    parameter int TW     = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [1:0]    cmd_i,
    input  logic [TW-1:0] t_w1_low_i,
    input  logic [TW-1:0] t_w0_low_i,
    input  logic [TW-1:0] t_rd_low_i,
    input  logic [TW-1:0] t_rd_valid_i,
    input  logic [TW-1:0] t_slot_i,
    input  logic [TW-1:0] t_recov_i,
    input  logic [TW-1:0] t_rst_low_i,
    input  logic [TW-1:0] t_pres_wait_i,
    input  logic [TW-1:0] t_pres_len_i,
    input  logic [TW-1:0] t_rst_high_i,
    input  logic          line_i,
    output logic          line_oe_o,
    output logic          busy_o,
    output logic          done_o,
    output logic [1:0]    result_o
);
    logic tick;
    logic tick_clr;
    logic line_s;

    ow_tick_gen #(
        .CLK_HZ  (CLK_HZ),
        .TICK_HZ (1_000_000)
    ) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (tick_clr),
        .tick_o (tick)
    );

    ow_line_sync #(
        .STAGES (2)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (line_i),
        .line_o (line_s)
    );

    ow_slot_fsm #(
        .TW (TW)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick_i        (tick),
        .line_s_i      (line_s),
        .start_i       (start_i),
        .cmd_i         (cmd_i),
        .t_w1_low_i    (t_w1_low_i),
        .t_w0_low_i    (t_w0_low_i),
        .t_rd_low_i    (t_rd_low_i),
        .t_rd_valid_i  (t_rd_valid_i),
        .t_slot_i      (t_slot_i),
        .t_recov_i     (t_recov_i),
        .t_rst_low_i   (t_rst_low_i),
        .t_pres_wait_i (t_pres_wait_i),
        .t_pres_len_i  (t_pres_len_i),
        .t_rst_high_i  (t_rst_high_i),
        .tick_clr_o    (tick_clr),
        .line_oe_o     (line_oe_o),
        .busy_o        (busy_o),
        .done_o        (done_o),
        .result_o      (result_o)
    );

endmodule

// File: tb/tb_ow_slot_master.sv
module tb_ow_slot_master;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 4_000_000;
    localparam int DIV        = CLK_HZ / 1_000_000;
    localparam int TW         = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [1:0] cmd = 2'd0;
    logic [TW-1:0] t_w1_low = 10'd6, t_w0_low = 10'd60, t_rd_low = 10'd6;
    logic [TW-1:0] t_rd_valid = 10'd15, t_slot = 10'd65, t_recov = 10'd5;
    logic [TW-1:0] t_rst_low = 10'd480, t_pres_wait = 10'd30;
    logic [TW-1:0] t_pres_len = 10'd120, t_rst_high = 10'd480;
    logic line_oe, busy, done;
    logic [1:0] result;
    logic slave_low = 1'b0, stuck_low = 1'b0;
    wire  line = ~(line_oe | slave_low | stuck_low);

    int smode = 0;     // 0 silent, 1 hold after master fall, 2 presence
    int hold_us = 0;
    int plen_us = 120;

    int cyc = 0;
    int tests = 0, fails = 0;

    typedef struct {
        int start;
        int width;
        int delay;
        logic [1:0] res;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ow_slot_master #(.CLK_HZ(CLK_HZ), .TW(TW)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .cmd_i(cmd),
        .t_w1_low_i(t_w1_low), .t_w0_low_i(t_w0_low), .t_rd_low_i(t_rd_low),
        .t_rd_valid_i(t_rd_valid), .t_slot_i(t_slot), .t_recov_i(t_recov),
        .t_rst_low_i(t_rst_low), .t_pres_wait_i(t_pres_wait),
        .t_pres_len_i(t_pres_len), .t_rst_high_i(t_rst_high),
        .line_i(line), .line_oe_o(line_oe), .busy_o(busy), .done_o(done),
        .result_o(result)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // target device model
    initial begin
        forever begin
            @(posedge line_oe);
            if (smode == 1) begin
                slave_low = 1'b1;
                repeat (hold_us * DIV) @(negedge clk);
                slave_low = 1'b0;
            end else if (smode == 2) begin
                @(negedge line_oe);
                repeat (int'(t_pres_wait) * DIV) @(negedge clk);
                slave_low = 1'b1;
                repeat (plen_us * DIV) @(negedge clk);
                slave_low = 1'b0;
            end
        end
    end

    // monitor: measures low pulses and matches each done against the queue
    initial begin
        int rise_c = 0;
        int width = 0;
        bit oe_prev = 1'b0;
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (line_oe && !oe_prev) rise_c = cyc;
                if (!line_oe && oe_prev) width = cyc - rise_c;
                oe_prev = line_oe;
                if (done) begin
                    if (sb.size() == 0) begin
                        chk(1'b0, "R10", "unexpected done", 1, 0);
                    end else begin
                        e = sb.pop_front();
                        chk(result == e.res, e.tag, "result", int'(result), int'(e.res));
                        chk((cyc - e.start) == e.delay, e.tag, "done delay",
                            cyc - e.start, e.delay);
                        chk(width == e.width, e.tag, "low width", width, e.width);
                    end
                    width = 0;
                end
            end
        end
    end

    task automatic do_slot(input logic [1:0] c, input int w_us, input int dly_us,
                           input logic [1:0] r, input string tag, input bit poke);
        exp_t e;
        @(negedge clk);
        start = 1'b1;
        cmd   = c;
        e.start = cyc + 1;
        e.width = w_us * DIV;
        e.delay = dly_us * DIV;
        e.res   = r;
        e.tag   = tag;
        sb.push_back(e);
        @(negedge clk);
        start = 1'b0;
        if (dly_us > 0) chk(busy == 1'b1, "R10", "busy after start", int'(busy), 1);
        if (poke) begin
            repeat (20 * DIV) @(negedge clk);
            start = 1'b1;
            cmd   = 2'd3;   // R9: reset request while busy must be ignored
            @(negedge clk);
            start = 1'b0;
        end
        wait (sb.size() == 0);
        repeat (8) @(negedge clk);
        chk(busy == 1'b0, "R10", "idle after done", int'(busy), 0);
    endtask

    initial begin
        repeat (200_000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(line_oe == 1'b0, "R1", "oe after reset", int'(line_oe), 0);
        chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
        chk(done == 1'b0, "R1", "done after reset", int'(done), 0);
        chk(result == 2'd0, "R1", "result after reset", int'(result), 0);

        // R2 / R3 writes
        do_slot(2'd1, 6, 70, 2'd0, "R2", 1'b0);
        do_slot(2'd0, 60, 70, 2'd0, "R3", 1'b0);
        t_w1_low = 10'd10;
        do_slot(2'd1, 10, 70, 2'd0, "R2", 1'b0);

        // R4 read: target releases at 12 us, before threshold
        smode = 1; hold_us = 12;
        do_slot(2'd2, 6, 70, 2'd1, "R4", 1'b0);
        // R4 read: line high right at release
        smode = 0;
        do_slot(2'd2, 6, 70, 2'd1, "R4", 1'b0);
        // R5 read: release at 16 us, past threshold but inside the watch
        smode = 1; hold_us = 16;
        do_slot(2'd2, 6, 70, 2'd0, "R5", 1'b0);
        // R5 read: never released within the watch
        hold_us = 40;
        do_slot(2'd2, 6, 70, 2'd0, "R5", 1'b0);
        smode = 0;

        // R7 presence and absence
        smode = 2; plen_us = 120;
        do_slot(2'd3, 480, 960, 2'd1, "R7", 1'b0);
        smode = 0;
        do_slot(2'd3, 480, 960, 2'd0, "R7", 1'b0);

        // R6 stuck low before reset
        stuck_low = 1'b1;
        repeat (5) @(negedge clk);
        do_slot(2'd3, 0, 0, 2'd2, "R6", 1'b0);
        chk(line_oe == 1'b0, "R6", "no drive on fault", int'(line_oe), 0);
        stuck_low = 1'b0;
        repeat (5) @(negedge clk);

        // R9 start while busy during a write-zero
        do_slot(2'd0, 60, 70, 2'd0, "R9", 1'b1);

        // R8 presence running past the high window
        smode = 2; plen_us = 600;
        do_slot(2'd3, 480, 960, 2'd2, "R8", 1'b0);
        smode = 0;
        repeat (200 * DIV) @(negedge clk);
        chk(line == 1'b1, "R8", "bus released later", int'(line), 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule